// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Unit

This unit carries out the two halves of an atomic read-modify-write sequence on 32-bit words. A load-and-reserve request issues a memory read and leaves a reservation behind. The reservation holds the word address that was read. A later conditional store writes memory only if that reservation is still in place and covers the same word. Each conditional store reports its outcome in a 4-bit condition field. The core then branches on that field to retry the sequence or leave it.

The unit sits beside the load/store path. Decode supplies the opcode fields, the base-register selector, and the two register operands. The unit forms the effective address and registers its outputs one cycle after the request. Those outputs are a read strobe, a write strobe, the address and store data, a condition-field update and an illegal-instruction flag. An external clear input drops the reservation, for example on a context switch or an exception.

Top module: `lrsc_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, all output strobes (`mem_re`, `mem_we`, `cr0_we`, `illegal`) are 0 and no reservation is held, so a first conditional store fails.
- R2: A request is recognised only when `op_prim` is 31. `op_ext` 20 selects load-and-reserve and `op_ext` 150 selects conditional store. Any other field value produces no strobe and leaves the reservation unchanged.
- R3: The effective address is `rb_val` when `ra_sel` is 0, and `ra_val + rb_val` (modulo 2^32) otherwise.
- R4: Load-and-reserve raises `mem_re` for one cycle, one cycle after the request, with `mem_addr` set to the effective address. It sets the reservation to the word address (effective address bits 31:2) and replaces any earlier reservation.
- R5: A conditional store succeeds when a reservation is held and its word address equals bits 31:2 of the effective address, whatever the low two bits are. On success, `mem_we` pulses one cycle later with `mem_addr` and `mem_wdata` set to the address and `st_data`, and the reservation is cleared.
- R6: A conditional store that finds no reservation, or a reservation on a different word, raises no `mem_we` and clears the reservation.
- R7: Every legal conditional store pulses `cr0_we` one cycle later. `cr0_val` replaces the field outright: bit 3 (less-than) and bit 2 (greater-than) are 0, bit 1 (equal) is 1 exactly on success, and bit 0 (summary overflow) copies `xer_so`.
- R8: A conditional store with `op_rc` = 0 is illegal. It pulses `illegal` one cycle later, with no `mem_we` and no `cr0_we`, and leaves the reservation as it was.
- R9: `resv_clr` drops the reservation at the next edge. It wins over a load-and-reserve in the same cycle and makes a conditional store in the same cycle fail.
- R10: All outputs are registered. At most one of `mem_re`, `cr0_we` and `illegal` is high in any cycle, and each pulse lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded request present this cycle |
| op_prim | input | 6 | Primary opcode field |
| op_ext | input | 10 | Extended opcode field |
| op_rc | input | 1 | Record bit of the instruction |
| ra_sel | input | 5 | Base register selector; 0 means no base |
| ra_val | input | 32 | Base register value |
| rb_val | input | 32 | Index register value |
| st_data | input | 32 | Word to store |
| xer_so | input | 1 | Summary-overflow bit (bit 31) of the exception register |
| resv_clr | input | 1 | Drop the reservation |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| cr0_we | output | 1 | Condition field 0 update strobe |
| cr0_val | output | 4 | New condition field 0 value {LT, GT, EQ, SO} |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The bench goes after these corner cases:

- **Byte offset within the reserved word.** It stores to a different byte offset inside the reserved word. A design that compared full byte addresses would fail that store.
- **Replacement by a second reservation.** It issues a second load-and-reserve to another word and then stores to the first word. A design that kept the first reservation would write.
- **Failed store still clears.** It repeats a store after a mismatch. A design that kept the reservation after a mismatch would succeed on the repeat.
- **Illegal store.** It issues a store with a clear record bit and then a legal store. A design that consumed the reservation on the illegal one would fail the legal store.
- **Same-cycle clear.** It asserts the clear input in the same cycle as a load-and-reserve, and in the same cycle as a store. A design that ordered these the wrong way would report a false success.
- **Base-register rule.** It uses `ra_sel` = 0 with a nonzero `ra_val`. A design that added the base anyway would present the wrong address.

// File: rtl/lrsc_unit.sv
module lrsc_unit #(
  parameter int          XLEN     = 32,
  parameter int          OFFS     = 2,
  parameter logic [5:0]  PRIM_OP  = 6'd31,
  parameter logic [9:0]  XO_LOAD  = 10'd20,
  parameter logic [9:0]  XO_STORE = 10'd150
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [5:0]      op_prim,
  input  logic [9:0]      op_ext,
  input  logic            op_rc,
  input  logic [4:0]      ra_sel,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic [XLEN-1:0] st_data,
  input  logic            xer_so,
  input  logic            resv_clr,
  output logic            mem_re,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            cr0_we,
  output logic [3:0]      cr0_val,
  output logic            illegal
);
  localparam int WA = XLEN - OFFS;

  logic            resv_q;
  logic [WA-1:0]   resv_word_q;
  logic [XLEN-1:0] ea;
  logic            is_ld, is_st, st_ok, st_bad, held, hit;

  assign ea     = ((ra_sel == 5'd0) ? '0 : ra_val) + rb_val;
  assign is_ld  = req_valid && (op_prim == PRIM_OP) && (op_ext == XO_LOAD);
  assign is_st  = req_valid && (op_prim == PRIM_OP) && (op_ext == XO_STORE);
  assign st_ok  = is_st && op_rc;
  assign st_bad = is_st && !op_rc;
  assign held   = resv_q && !resv_clr;
  assign hit    = held && (resv_word_q == ea[XLEN-1:OFFS]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_q      <= 1'b0;
      resv_word_q <= '0;
    end else if (resv_clr) begin
      resv_q <= 1'b0;
    end else if (is_ld) begin
      resv_q      <= 1'b1;
      resv_word_q <= ea[XLEN-1:OFFS];
    end else if (st_ok) begin
      resv_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cr0_we    <= 1'b0;
      cr0_val   <= 4'd0;
      illegal   <= 1'b0;
    end else begin
      mem_re    <= is_ld;
      mem_we    <= st_ok && hit;
      mem_addr  <= ea;
      mem_wdata <= st_data;
      cr0_we    <= st_ok;
      cr0_val   <= st_ok ? {2'b00, hit, xer_so} : 4'd0;
      illegal   <= st_bad;
    end
  end

  AST_WRITE_REPORTS_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cr0_we && cr0_val[1])); // R5
  AST_WRITE_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !resv_q); // R5
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cr0_we && !cr0_val[1]) |-> !mem_we); // R6
  AST_CR0_LTGT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_we |-> (cr0_val[3:2] == 2'b00)); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_we && !cr0_we)); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    resv_clr |=> !resv_q); // R9
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re, cr0_we, illegal})); // R10
endmodule

// File: tb/lrsc_unit_bench.sv
module lrsc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  op_prim = '0;
  logic [9:0]  op_ext = '0;
  logic        op_rc = 1'b0;
  logic [4:0]  ra_sel = '0;
  logic [31:0] ra_val = '0, rb_val = '0, st_data = '0;
  logic        xer_so = 1'b0, resv_clr = 1'b0;
  logic        mem_re, mem_we, cr0_we, illegal;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  cr0_val;

  always #5 clk = ~clk;

  lrsc_unit u_lrsc_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_prim(op_prim),
    .op_ext(op_ext), .op_rc(op_rc), .ra_sel(ra_sel), .ra_val(ra_val),
    .rb_val(rb_val), .st_data(st_data), .xer_so(xer_so), .resv_clr(resv_clr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cr0_we(cr0_we), .cr0_val(cr0_val), .illegal(illegal));

  typedef struct {
    logic        re, we, crwe, ill;
    logic [31:0] addr, wdata;
    logic [3:0]  cr;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_bad = 0;
  logic        m_resv = 1'b0;
  logic [29:0] m_word = '0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "mem_re", {31'd0, mem_re}, {31'd0, e.re});
      check(e.tag, "mem_we", {31'd0, mem_we}, {31'd0, e.we});
      check(e.tag, "cr0_we", {31'd0, cr0_we}, {31'd0, e.crwe});
      check(e.tag, "illegal", {31'd0, illegal}, {31'd0, e.ill});
      if (e.re || e.we) check(e.tag, "mem_addr", mem_addr, e.addr);
      if (e.we) check(e.tag, "mem_wdata", mem_wdata, e.wdata);
      if (e.crwe) check(e.tag, "cr0_val", {28'd0, cr0_val}, {28'd0, e.cr});
    end
  end

  // Drives one cycle and pushes the reference outcome computed from R2..R9.
  task automatic step(input string tag, input logic v, input logic [5:0] p, input logic [9:0] x,
                      input logic rc, input logic [4:0] ras, input logic [31:0] ra,
                      input logic [31:0] rb, input logic [31:0] d, input logic so, input logic clr);
    exp_t e;
    logic [31:0] ea;
    logic ld, st, hit;
    @(negedge clk);
    req_valid = v; op_prim = p; op_ext = x; op_rc = rc; ra_sel = ras;
    ra_val = ra; rb_val = rb; st_data = d; xer_so = so; resv_clr = clr;
    ea  = (ras == 5'd0) ? rb : ra + rb;
    ld  = v && p == 6'd31 && x == 10'd20;
    st  = v && p == 6'd31 && x == 10'd150;
    hit = m_resv && !clr && m_word == ea[31:2];
    e.re = ld; e.we = st && rc && hit; e.crwe = st && rc; e.ill = st && !rc;
    e.addr = ea; e.wdata = d; e.cr = {2'b00, hit, so}; e.tag = tag;
    if (clr) m_resv = 1'b0;
    else if (ld) begin m_resv = 1'b1; m_word = ea[31:2]; end
    else if (st && rc) m_resv = 1'b0;
    @(posedge clk); #1;
    sb.push_back(e);
    req_valid = 1'b0; resv_clr = 1'b0;
  endtask

  task automatic lwarx(input string t, input logic [4:0] s, input logic [31:0] a, input logic [31:0] b, input logic clr);
    step(t, 1'b1, 6'd31, 10'd20, 1'b0, s, a, b, 32'h0, 1'b0, clr);
  endtask
  task automatic stwcx(input string t, input logic rc, input logic [4:0] s, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] d, input logic so, input logic clr);
    step(t, 1'b1, 6'd31, 10'd150, rc, s, a, b, d, so, clr);
  endtask

  logic done = 1'b0;
  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "strobes in reset", {28'd0, mem_re, mem_we, cr0_we, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "strobes after reset", {28'd0, mem_re, mem_we, cr0_we, illegal}, 32'd0);
    stwcx("R1_R6", 1'b1, 5'd0, 32'h0, 32'h100, 32'hAAAA0001, 1'b0, 1'b0);
    lwarx("R3_R4", 5'd0, 32'hDEAD0000, 32'h200, 1'b0);
    stwcx("R5_R7", 1'b1, 5'd3, 32'h100, 32'h103, 32'h12345678, 1'b1, 1'b0);
    stwcx("R5_R6", 1'b1, 5'd0, 32'h0, 32'h200, 32'h1, 1'b0, 1'b0);
    lwarx("R4", 5'd2, 32'h1000, 32'h10, 1'b0);
    lwarx("R4", 5'd2, 32'h2000, 32'h10, 1'b0);
    stwcx("R4_R6", 1'b1, 5'd0, 32'h0, 32'h1010, 32'h2, 1'b1, 1'b0);
    stwcx("R6", 1'b1, 5'd0, 32'h0, 32'h2010, 32'h3, 1'b0, 1'b0);
    lwarx("R4", 5'd1, 32'hFFFFFFF0, 32'h20, 1'b0);
    stwcx("R8", 1'b0, 5'd0, 32'h0, 32'h10, 32'h4, 1'b0, 1'b0);
    stwcx("R8_R5", 1'b1, 5'd0, 32'h0, 32'h10, 32'h5, 1'b0, 1'b0);
    lwarx("R4", 5'd0, 32'h0, 32'h300, 1'b0);
    step("R9", 1'b0, 6'd0, 10'd0, 1'b0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1);
    stwcx("R9", 1'b1, 5'd0, 32'h0, 32'h300, 32'h6, 1'b0, 1'b0);
    lwarx("R9", 5'd0, 32'h0, 32'h400, 1'b1);
    stwcx("R9", 1'b1, 5'd0, 32'h0, 32'h400, 32'h7, 1'b1, 1'b0);
    lwarx("R4", 5'd0, 32'h0, 32'h500, 1'b0);
    stwcx("R9", 1'b1, 5'd0, 32'h0, 32'h500, 32'h8, 1'b0, 1'b1);
    lwarx("R4", 5'd0, 32'h0, 32'h600, 1'b0);
    step("R2", 1'b1, 6'd31, 10'd23, 1'b1, 5'd0, 32'h0, 32'h600, 32'h9, 1'b0, 1'b0);
    step("R2", 1'b1, 6'd30, 10'd150, 1'b1, 5'd0, 32'h0, 32'h600, 32'h9, 1'b0, 1'b0);
    step("R2_R10", 1'b0, 6'd31, 10'd150, 1'b1, 5'd0, 32'h0, 32'h600, 32'h9, 1'b0, 1'b0);
    stwcx("R2_R5", 1'b1, 5'd4, 32'h5FF, 32'h1, 32'hCAFEF00D, 1'b1, 1'b0);
    step("R10", 1'b0, 6'd0, 10'd0, 1'b0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule